// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a processor's load/store port and a memory bus that moves one whole 32-bit word per transaction. It accepts a byte address, an access size of one, two or four bytes, a read/write flag, a signed-load flag and store data. An access that fits inside one bus word is done as a single beat. An access that runs past the end of its word is done either as two word beats, with the bytes merged on a load or split across byte strobes on a store, or it is refused with a fault and no bus traffic. The choice depends on a mode input.

A second configuration input selects little-endian or big-endian byte order for the access. Both configuration inputs are sampled when the request is accepted. Every response reports whether the access was atomic. Atomic here means it was done as exactly one bus beat and did not fault.

Top module: `misalign_splitter`

## Requirements
- R1: An access that stays inside one 32-bit word (any byte, a halfword with address low bits 0, 1 or 2, a word with low bits 0) is done as exactly one bus beat. That beat's `mem_addr` is the request address with bits [1:0] cleared, and the response has `rsp_atomic`=1 and `rsp_fault`=0.
- R2: A halfword with address low bits 3, or a word with nonzero low bits, crosses a word. When fault mode is off it is done as two beats: the lower word first (address with bits [1:0] cleared), then that address plus 4. Its response has `rsp_atomic`=0.
- R3: With `cfg_big_endian`=0, the byte at word offset o sits in lane o (bits 8o+7..8o), and value byte k (k=0 is least significant) comes from address addr+k. With `cfg_big_endian`=1, the byte at offset o sits in lane 3-o, and value byte k comes from address addr+n-1-k, where n is the access size in bytes.
- R4: `req_size` is encoded as 0 = byte, 1 = halfword, 2 = word (3 acts as word). A one- or two-byte load is sign-extended to 32 bits when `req_signed`=1 and zero-extended otherwise.
- R5: Each store beat sets `mem_strb` only for the lanes that hold bytes of the access. Memory bytes outside the access keep their values.
- R6: With `cfg_fault_mode`=1, a word-crossing access raises `rsp_fault`=1 one cycle after acceptance, with `rsp_rdata`=0, `rsp_atomic`=0 and no bus beat. Accesses that do not cross a word behave as in R1.
- R7: `req_ready` is high only when the block is idle. `busy` is high from the cycle after acceptance through the response cycle. `mem_valid`, `mem_addr` and `mem_strb` hold steady until `mem_ready` is seen.
- R8: `rsp_valid` is a single-cycle pulse in the cycle after the last beat's `mem_ready`. A store response carries `rsp_rdata`=0.
- R9: With `cfg_fault_mode`=0, a word-crossing access never reports `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian | input | 1 | 1 selects big-endian byte order |
| cfg_fault_mode | input | 1 | 1 faults word-crossing accesses instead of splitting them |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_wdata | input | 32 | Store value, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Extended load value |
| rsp_fault | output | 1 | Misalignment fault |
| rsp_atomic | output | 1 | Access was done as one bus beat |
| busy | output | 1 | Access in progress |
| mem_valid | output | 1 | Bus beat request |
| mem_ready | input | 1 | Bus beat completes this cycle |
| mem_addr | output | ADDR_W | Word-aligned bus address |
| mem_write | output | 1 | Beat is a write |
| mem_wdata | output | 32 | Write word |
| mem_strb | output | 4 | Byte-lane write strobes |
| mem_rdata | input | 32 | Read word, valid while mem_ready is high |

## Verification
Take the edge that accepts a request as cycle 0. The response is due after `beats*(w+1)+1` cycles, where w is the number of wait cycles the bench memory inserts before each `mem_ready`. That is 2 cycles for a single beat with no waits, 3 for a split, and 1 for a fault. The bench samples on the falling clock edge and counts these cycles after acceptance. It checks the measured latency against the formula, then checks the data, fault, atomic flag, the beat log (count, addresses, strobes) and the memory contents against a byte-level reference model. One scenario inserts wait cycles to confirm that the latency grows with them and that `busy` stays high throughout.

// File: rtl/misalign_splitter_pkg.sv
// Package: shared types and helpers for the misaligned access splitter.
// Assumes a 32-bit bus word of four byte lanes.
package misalign_splitter_pkg;
    localparam int LANES = 4;
    localparam int WORD_W = LANES * 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef logic [LANES-1:0][7:0] word_t;

    typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1, ST_RESP} fsm_e;

    // Number of bytes moved by a size code (code 3 treated as a word).
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // True when the access runs past the end of its bus word.
    function automatic logic crosses_word(input logic [1:0] off, input logic [1:0] sz);
        crosses_word = ({2'b00, off} + {1'b0, size_bytes(sz)}) > 4'd4;
    endfunction
endpackage

// File: rtl/misalign_splitter_lane_plan.sv
// Lane planner: for an access of the given offset/size/byte order, computes
// the write strobes and positioned store data for the first and second word.
// Purely combinational; assumes offset+size never exceeds eight bytes.
module misalign_splitter_lane_plan
    import misalign_splitter_pkg::*;
(
    input  logic [1:0]        offset_i,
    input  logic [1:0]        size_i,
    input  logic              big_end_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [LANES-1:0]  strb0_o,
    output logic [LANES-1:0]  strb1_o,
    output logic [WORD_W-1:0] word0_o,
    output logic [WORD_W-1:0] word1_o
);
    word_t      src;
    word_t      out0;
    word_t      out1;
    logic [3:0] lo;
    logic [3:0] n4;
    logic [3:0] pos;
    logic [3:0] rel;
    logic [3:0] vidx;
    logic [1:0] lane;

    assign src = wdata_i;

    // Walk the eight byte addresses of the two-word window and place each byte.
    always_comb begin
        lo      = {2'b00, offset_i};
        n4      = {1'b0, size_bytes(size_i)};
        strb0_o = '0;
        strb1_o = '0;
        out0    = '0;
        out1    = '0;
        pos     = '0;
        rel     = '0;
        vidx    = '0;
        lane    = '0;
        for (int j = 0; j < 2 * LANES; j++) begin
            pos = 4'(j);
            if (pos >= lo && pos < lo + n4) begin
                rel  = pos - lo;
                vidx = big_end_i ? (n4 - 4'd1 - rel) : rel;
                lane = big_end_i ? ~pos[1:0] : pos[1:0];
                if (pos[2]) begin
                    strb1_o[lane] = 1'b1;
                    out1[lane]    = src[vidx[1:0]];
                end else begin
                    strb0_o[lane] = 1'b1;
                    out0[lane]    = src[vidx[1:0]];
                end
            end
        end
    end

    assign word0_o = out0;
    assign word1_o = out1;
endmodule

// File: rtl/misalign_splitter_load_merge.sv
// Load merger: gathers the requested bytes from the one or two captured bus
// words in the selected byte order and extends them to 32 bits.
// Purely combinational; word1_i is ignored when the access does not cross.
module misalign_splitter_load_merge
    import misalign_splitter_pkg::*;
(
    input  logic [WORD_W-1:0] word0_i,
    input  logic [WORD_W-1:0] word1_i,
    input  logic [1:0]        offset_i,
    input  logic [1:0]        size_i,
    input  logic              big_end_i,
    input  logic              signed_i,
    output logic [WORD_W-1:0] value_o
);
    word_t      w0;
    word_t      w1;
    word_t      val;
    logic [3:0] n4;
    logic [3:0] pos;
    logic [1:0] lane;
    logic       fill;

    assign w0 = word0_i;
    assign w1 = word1_i;

    // Pick value byte k from its memory address in the two-word window.
    always_comb begin
        n4   = {1'b0, size_bytes(size_i)};
        val  = '0;
        pos  = '0;
        lane = '0;
        for (int k = 0; k < LANES; k++) begin
            if (4'(k) < n4) begin
                pos  = {2'b00, offset_i} + (big_end_i ? (n4 - 4'd1 - 4'(k)) : 4'(k));
                lane = big_end_i ? ~pos[1:0] : pos[1:0];
                val[k] = pos[2] ? w1[lane] : w0[lane];
            end
        end
    end

    // Sign or zero extension by access size.
    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                fill    = signed_i & val[0][7];
                value_o = {{24{fill}}, val[0]};
            end
            SZ_HALF: begin
                fill    = signed_i & val[1][7];
                value_o = {{16{fill}}, val[1], val[0]};
            end
            default: begin
                fill    = 1'b0;
                value_o = val;
            end
        endcase
    end
endmodule

// File: rtl/misalign_splitter.sv
// Misaligned access splitter top: accepts one load/store at a time, issues one
// or two word beats (or faults in fault mode) and returns a single response.
// Assumes mem_rdata is valid in the cycle mem_ready is high; configuration is
// sampled at request acceptance.
module misalign_splitter
    import misalign_splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              cfg_fault_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_signed,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_fault,
    output logic              rsp_atomic,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_strb,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int WA = ADDR_W - 2;
    localparam logic [WA-1:0] WORD_STEP = WA'(1);

    fsm_e              state;
    logic [WA-1:0]     base_q;
    logic [1:0]        off_q;
    logic [1:0]        size_q;
    logic              write_q;
    logic              signed_q;
    logic              be_q;
    logic              split_q;
    logic              fault_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rd0_q;
    logic [WORD_W-1:0] rd1_q;
    logic              accept;
    logic              crossing;
    logic [LANES-1:0]  strb0;
    logic [LANES-1:0]  strb1;
    logic [WORD_W-1:0] wword0;
    logic [WORD_W-1:0] wword1;
    logic [WORD_W-1:0] merged;

    assign accept   = req_valid && req_ready;
    assign crossing = crosses_word(req_addr[1:0], req_size);

    // Sequencer: idle -> beat0 -> (beat1) -> response, or idle -> response on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= (crossing && cfg_fault_mode) ? ST_RESP : ST_BEAT0;
                ST_BEAT0: if (mem_ready) state <= split_q ? ST_BEAT1 : ST_RESP;
                ST_BEAT1: if (mem_ready) state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            off_q    <= '0;
            size_q   <= SZ_BYTE;
            write_q  <= 1'b0;
            signed_q <= 1'b0;
            be_q     <= 1'b0;
            split_q  <= 1'b0;
            fault_q  <= 1'b0;
            wdata_q  <= '0;
        end else if (accept) begin
            base_q   <= req_addr[ADDR_W-1:2];
            off_q    <= req_addr[1:0];
            size_q   <= req_size;
            write_q  <= req_write;
            signed_q <= req_signed;
            be_q     <= cfg_big_endian;
            split_q  <= crossing && !cfg_fault_mode;
            fault_q  <= crossing && cfg_fault_mode;
            wdata_q  <= req_wdata;
        end
    end

    // Read word capture on each completed beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0_q <= '0;
            rd1_q <= '0;
        end else if (mem_valid && mem_ready) begin
            if (state == ST_BEAT1) rd1_q <= mem_rdata;
            else                   rd0_q <= mem_rdata;
        end
    end

    misalign_splitter_lane_plan u_plan (
        .offset_i  (off_q),
        .size_i    (size_q),
        .big_end_i (be_q),
        .wdata_i   (wdata_q),
        .strb0_o   (strb0),
        .strb1_o   (strb1),
        .word0_o   (wword0),
        .word1_o   (wword1)
    );

    misalign_splitter_load_merge u_merge (
        .word0_i   (rd0_q),
        .word1_i   (rd1_q),
        .offset_i  (off_q),
        .size_i    (size_q),
        .big_end_i (be_q),
        .signed_i  (signed_q),
        .value_o   (merged)
    );

    assign req_ready  = (state == ST_IDLE);
    assign busy       = (state != ST_IDLE);
    assign mem_valid  = (state == ST_BEAT0) || (state == ST_BEAT1);
    assign mem_addr   = {((state == ST_BEAT1) ? base_q + WORD_STEP : base_q), 2'b00};
    assign mem_write  = write_q;
    assign mem_wdata  = (state == ST_BEAT1) ? wword1 : wword0;
    assign mem_strb   = (state == ST_BEAT1) ? strb1 : strb0;
    assign rsp_valid  = (state == ST_RESP);
    assign rsp_fault  = fault_q;
    assign rsp_atomic = !split_q && !fault_q;
    assign rsp_rdata  = (write_q || fault_q) ? '0 : merged;

    // R7: a stalled beat keeps its address and strobes.
    a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_strb)));

    // R2: the second beat of a split goes to the next word.
    a_r2_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT0 && mem_ready && split_q) |=>
        (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R6: a faulted access answers next cycle without any bus beat.
    a_r6_fault_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_fault_mode && crossing) |=> (rsp_valid && rsp_fault && !mem_valid));

    // R8: the response is a one-cycle pulse.
    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1: an atomic response follows a completed beat and carries no fault.
    a_r1_atomic_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_atomic) |-> (!rsp_fault && $past(mem_valid && mem_ready)));

    // R5: every beat enables at least one lane.
    a_r5_strb_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_strb != '0));
endmodule

// File: tb/misalign_splitter_tb_top.sv
// Directed bench for the misaligned access splitter with a 16-byte memory model.
module misalign_splitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_big_endian = 1'b0;
    logic          cfg_fault_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic          req_write = 1'b0;
    logic          req_signed = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_fault;
    logic          rsp_atomic;
    logic          busy;
    logic          mem_valid;
    logic          mem_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_write;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_strb;
    logic [31:0]   mem_rdata;

    logic [31:0] mem_w [4];
    logic [31:0] sh_w [4];
    int          wait_n = 0;
    int          wcnt = 0;
    int          nbeat = 0;
    logic [AW-1:0] log_addr [4];
    logic [3:0]    log_strb [4];

    int checks = 0;
    int errors = 0;

    logic [31:0] got_rdata;
    logic        got_fault;
    logic        got_atomic;
    logic        busy_ok;
    int          got_lat;
    int          got_beats;
    int          beat0;

    always #(CLK_PERIOD/2) clk = ~clk;

    misalign_splitter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_big_endian(cfg_big_endian), .cfg_fault_mode(cfg_fault_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_signed(req_signed),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_fault(rsp_fault), .rsp_atomic(rsp_atomic), .busy(busy),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_w[mem_addr[3:2]];
    assign mem_ready = mem_valid && (wcnt >= wait_n);

    // Memory model: applies strobed writes and logs each completed beat.
    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_write)
                for (int k = 0; k < 4; k++)
                    if (mem_strb[k]) mem_w[mem_addr[3:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            log_addr[nbeat % 4] <= mem_addr;
            log_strb[nbeat % 4] <= mem_strb;
            nbeat <= nbeat + 1;
            wcnt  <= 0;
        end else if (mem_valid) begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: byte at address a from a word array in the given order.
    function automatic logic [7:0] ref_byte(input logic [31:0] w [4], input logic [3:0] a, input logic be);
        logic [1:0] ln;
        ln = be ? 2'(3 - a[1:0]) : a[1:0];
        return w[a[3:2]][8*ln +: 8];
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ref_load(input logic [3:0] a, input logic [1:0] sz,
                                             input logic sg, input logic be);
        logic [31:0] v;
        int n;
        n = nbytes(sz);
        v = '0;
        for (int k = 0; k < n; k++)
            v[8*k +: 8] = ref_byte(mem_w, 4'(a + (be ? n - 1 - k : k)), be);
        if (sg && n == 1 && v[7])  v[31:8]  = '1;
        if (sg && n == 2 && v[15]) v[31:16] = '1;
        return v;
    endfunction

    // Shadow store: place value bytes into sh_w in the given order.
    task automatic ref_store(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d, input logic be);
        int n;
        logic [3:0] ad;
        logic [1:0] ln;
        n = nbytes(sz);
        for (int k = 0; k < n; k++) begin
            ad = 4'(a + (be ? n - 1 - k : k));
            ln = be ? 2'(3 - ad[1:0]) : ad[1:0];
            sh_w[ad[3:2]][8*ln +: 8] = d[8*k +: 8];
        end
    endtask

    // Issue one access and measure latency in cycles after the accepting edge.
    task automatic access(input logic [3:0] a, input logic [1:0] sz, input logic wr,
                          input logic sg, input logic [31:0] d, input logic be, input logic fm);
        @(negedge clk);
        cfg_big_endian = be;
        cfg_fault_mode = fm;
        req_addr   = AW'(a);
        req_size   = sz;
        req_write  = wr;
        req_signed = sg;
        req_wdata  = d;
        req_valid  = 1'b1;
        beat0      = nbeat;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_lat   = 1;
        busy_ok   = 1'b1;
        while (!rsp_valid && got_lat < 100) begin
            if (!busy || req_ready) busy_ok = 1'b0;
            @(negedge clk);
            got_lat++;
        end
        if (!busy || req_ready) busy_ok = 1'b0;
        got_rdata  = rsp_rdata;
        got_fault  = rsp_fault;
        got_atomic = rsp_atomic;
        got_beats  = nbeat - beat0;
        @(negedge clk);
        check("R8 rsp pulse ends", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R7 reset req_ready", {31'b0, req_ready}, 32'd1);
        check("R7 reset busy", {31'b0, busy}, 32'd0);
        check("R8 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R7 reset mem_valid", {31'b0, mem_valid}, 32'd0);
    endtask

    task automatic t_aligned_word();
        access(4'd4, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        check("R1 word load value", got_rdata, ref_load(4'd4, 2'd2, 1'b0, 1'b0));
        check("R1 one beat", got_beats, 1);
        check("R1 beat address", log_addr[beat0 % 4], 32'd4);
        check("R1 atomic", {31'b0, got_atomic}, 32'd1);
        check("R8 single beat latency", got_lat, 2);
        check("R7 busy during access", {31'b0, busy_ok}, 32'd1);
    endtask

    task automatic t_narrow_loads();
        for (int be = 0; be < 2; be++)
            for (int o = 0; o < 4; o++)
                for (int sg = 0; sg < 2; sg++) begin
                    access(4'(8 + o), 2'd0, 1'b0, sg[0], '0, be[0], 1'b0);
                    check("R3 R4 byte load", got_rdata, ref_load(4'(8 + o), 2'd0, sg[0], be[0]));
                end
        check("R3 LE byte lane 3 signed", ref_load(4'd11, 2'd0, 1'b1, 1'b0), 32'hFFFF_FFF3);
        access(4'd9, 2'd1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
        check("R4 BE half signed", got_rdata, ref_load(4'd9, 2'd1, 1'b1, 1'b1));
        check("R1 half at offset 1 one beat", got_beats, 1);
        check("R1 half at offset 1 atomic", {31'b0, got_atomic}, 32'd1);
        access(4'd2, 2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        check("R4 LE half unsigned", got_rdata, ref_load(4'd2, 2'd1, 1'b0, 1'b0));
    endtask

    task automatic t_split_load();
        access(4'd3, 2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        check("R2 R3 LE split half", got_rdata, ref_load(4'd3, 2'd1, 1'b0, 1'b0));
        check("R2 two beats", got_beats, 2);
        check("R2 first beat addr", log_addr[beat0 % 4], 32'd0);
        check("R2 second beat addr", log_addr[(beat0 + 1) % 4], 32'd4);
        check("R2 not atomic", {31'b0, got_atomic}, 32'd0);
        check("R9 no fault when splitting", {31'b0, got_fault}, 32'd0);
        check("R8 split latency", got_lat, 3);
        access(4'd3, 2'd1, 1'b0, 1'b1, '0, 1'b1, 1'b0);
        check("R3 BE split half signed", got_rdata, ref_load(4'd3, 2'd1, 1'b1, 1'b1));
        check("R5 BE beat0 lane strobe", {28'b0, log_strb[beat0 % 4]}, 32'h1);
        check("R5 BE beat1 lane strobe", {28'b0, log_strb[(beat0 + 1) % 4]}, 32'h8);
        access(4'd5, 2'd2, 1'b0, 1'b0, '0, 1'b1, 1'b0);
        check("R2 R3 BE split word", got_rdata, ref_load(4'd5, 2'd2, 1'b0, 1'b1));
    endtask

    task automatic t_split_store();
        for (int i = 0; i < 4; i++) sh_w[i] = mem_w[i];
        ref_store(4'd6, 2'd2, 32'hCAFE_1234, 1'b0);
        access(4'd6, 2'd2, 1'b1, 1'b0, 32'hCAFE_1234, 1'b0, 1'b0);
        check("R5 LE store beat0 strb", {28'b0, log_strb[beat0 % 4]}, 32'hC);
        check("R5 LE store beat1 strb", {28'b0, log_strb[(beat0 + 1) % 4]}, 32'h3);
        check("R8 store rdata zero", got_rdata, 32'd0);
        for (int i = 0; i < 4; i++) check("R5 LE store memory", mem_w[i], sh_w[i]);
        ref_store(4'd11, 2'd1, 32'h0000_BEEF, 1'b1);
        access(4'd11, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) check("R5 R3 BE store memory", mem_w[i], sh_w[i]);
    endtask

    task automatic t_fault();
        for (int i = 0; i < 4; i++) sh_w[i] = mem_w[i];
        access(4'd1, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b1);
        check("R6 fault raised", {31'b0, got_fault}, 32'd1);
        check("R6 no beats", got_beats, 0);
        check("R6 fault latency", got_lat, 1);
        check("R6 fault rdata zero", got_rdata, 32'd0);
        check("R6 fault not atomic", {31'b0, got_atomic}, 32'd0);
        access(4'd7, 2'd1, 1'b1, 1'b0, 32'h0000_5A5A, 1'b0, 1'b1);
        check("R6 faulted store no beats", got_beats, 0);
        for (int i = 0; i < 4; i++) check("R6 memory untouched", mem_w[i], sh_w[i]);
        access(4'd8, 2'd2, 1'b0, 1'b0, '0, 1'b1, 1'b1);
        check("R6 aligned no fault", {31'b0, got_fault}, 32'd0);
        check("R6 aligned value", got_rdata, ref_load(4'd8, 2'd2, 1'b0, 1'b1));
    endtask

    task automatic t_wait();
        wait_n = 2;
        access(4'd7, 2'd2, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        check("R8 latency with waits", got_lat, 7);
        check("R7 busy held through waits", {31'b0, busy_ok}, 32'd1);
        check("R2 value with waits", got_rdata, ref_load(4'd7, 2'd2, 1'b0, 1'b0));
        wait_n = 0;
    endtask

    initial begin
        mem_w[0] = 32'h8A17_3C5E;
        mem_w[1] = 32'h4D92_E0B1;
        mem_w[2] = 32'hF3E2_D1C0;
        mem_w[3] = 32'h7F80_01FE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned_word();
        t_narrow_loads();
        t_split_load();
        t_split_store();
        t_fault();
        t_wait();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule